// File: doc/BRIEF.md
# In-Place Exchange Sort Engine

This block holds a small array of unsigned words in an internal single-port synchronous RAM and sorts it in place into ascending order. A host fills the array while the mode input is low, using a write strobe together with an address and a data word. It raises the mode input to start the engine. When the engine reports completion, the host reads the sorted words back through a gated read port.

The engine is split into a controller FSM and a datapath. The datapath holds two word registers (the running minimum and the candidate), two index counters, a magnitude comparator and the address and write-data multiplexers. For each outer index, the controller loads the minimum register from the outer position. It then walks the inner index over every later position. Whenever the minimum is strictly larger than the candidate, it exchanges the two memory words and reloads the minimum. Because the RAM read is registered, every address change is followed by one wait state before the read word is captured.

Top module: `xsort_engine`

## Requirements
- R1: While the engine is idle (mode_i low), a cycle with host_wr_i high writes host_data_i into the word at host_addr_i on that clock edge.
- R2: With host_rd_en_i high and the engine idle or done, data_o shows the word at host_addr_i one clock edge after the address is applied. With host_rd_en_i low, data_o is zero.
- R3: A rising mode_i in the idle state starts a sort. At completion, addresses 0 to COUNT-1 hold the original words in ascending unsigned order.
- R4: done_o goes high when the sort ends and stays high while mode_i stays high. It goes low on the first clock edge that samples mode_i low, and the engine is then idle again and can run a new sort.
- R5: Counting the edge that samples mode_i high, a sort finishes after exactly 1 + 2(COUNT-1) + 2·COUNT·(COUNT-1) + 4·S clock edges, where S is the number of exchanges. An exchange happens only when the minimum is strictly greater than the candidate, so equal words are never exchanged.
- R6: The active-low asynchronous reset rst_ni clears done_o and returns the engine to idle. It leaves the RAM contents unchanged.
- R7: While a sort runs, host_wr_i, host_addr_i and host_data_i have no effect on the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = host access, 1 = run sort |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | ADDR_W | Host word address |
| host_data_i | input | DATA_W | Host write data |
| host_rd_en_i | input | 1 | Gates the read word onto data_o |
| data_o | output | DATA_W | Read word, zero when not enabled |
| done_o | output | 1 | Sort finished |

## Verification
Two activities can fall in the same cycle: a host write strobe and the engine's own exchange write-back, both of which drive the single RAM port. The bench holds host_wr_i high with a fixed address and data throughout a sort of a reverse-ordered array, which forces a collision with every exchange cycle. It judges the run by the read-back contents and by the cycle count, and both must match a run with no host activity. A second overlap, done_o together with a host read, is covered by reading the array back while done_o is still high.

// File: rtl/xsort_pkg.sv
package xsort_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_A, ST_LD_A, ST_RD_B, ST_LD_B, ST_CMP,
    ST_WR_I, ST_WR_J, ST_RL_RD, ST_RL_LD, ST_NEXT, ST_DONE
  } xs_state_e;

  typedef struct packed {
    logic host_sel;  // host owns the RAM port
    logic i_clr;
    logic i_inc;
    logic j_load;
    logic j_inc;
    logic a_en;
    logic b_en;
    logic addr_j;    // 1: address from j, 0: from i
    logic wdat_b;    // 1: write B, 0: write A
    logic wr;
  } xs_ctrl_t;
endpackage

// File: rtl/xsort_ram.sv
module xsort_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/xsort_datapath.sv
module xsort_datapath
  import xsort_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int COUNT  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  xs_ctrl_t          ctrl_i,
  input  logic              host_wr_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_data_i,
  input  logic              host_rd_en_i,
  output logic [DATA_W-1:0] data_o,
  output logic              i_last_o,
  output logic              j_last_o,
  output logic              a_gt_b_o
);
  localparam logic [ADDR_W-1:0] I_END = ADDR_W'(COUNT - 2);
  localparam logic [ADDR_W-1:0] J_END = ADDR_W'(COUNT - 1);

  logic [DATA_W-1:0] a_q, b_q, rdata, wdata;
  logic [ADDR_W-1:0] i_q, j_q, addr;
  logic              we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_q <= '0;
      j_q <= '0;
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (ctrl_i.i_clr)       i_q <= '0;
      else if (ctrl_i.i_inc)  i_q <= i_q + 1'b1;
      if (ctrl_i.j_load)      j_q <= i_q + 1'b1;
      else if (ctrl_i.j_inc)  j_q <= j_q + 1'b1;
      if (ctrl_i.a_en)        a_q <= rdata;
      if (ctrl_i.b_en)        b_q <= rdata;
    end
  end

  always_comb begin
    if (ctrl_i.host_sel) begin
      addr  = host_addr_i;
      wdata = host_data_i;
      we    = host_wr_i;
    end else begin
      addr  = ctrl_i.addr_j ? j_q : i_q;
      wdata = ctrl_i.wdat_b ? b_q : a_q;
      we    = ctrl_i.wr;
    end
  end

  xsort_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  assign data_o   = host_rd_en_i ? rdata : '0;
  assign i_last_o = (i_q == I_END);
  assign j_last_o = (j_q == J_END);
  assign a_gt_b_o = (a_q > b_q);

  assert_idx_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i_q <= I_END) && (j_q <= J_END));
  assert_j_after_i_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.b_en |-> (j_q > i_q));
endmodule

// File: rtl/xsort_ctrl.sv
module xsort_ctrl
  import xsort_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     mode_i,
  input  logic     i_last_i,
  input  logic     j_last_i,
  input  logic     a_gt_b_i,
  output xs_ctrl_t ctrl_o,
  output logic     done_o
);
  xs_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    ctrl_o  = '0;
    unique case (state_q)
      ST_IDLE: begin
        ctrl_o.host_sel = 1'b1;
        if (mode_i) begin
          ctrl_o.i_clr = 1'b1;
          state_d      = ST_RD_A;
        end
      end
      ST_RD_A:  state_d = ST_LD_A;
      ST_LD_A: begin
        ctrl_o.a_en   = 1'b1;
        ctrl_o.j_load = 1'b1;
        state_d       = ST_RD_B;
      end
      ST_RD_B: begin
        ctrl_o.addr_j = 1'b1;
        state_d       = ST_LD_B;
      end
      ST_LD_B: begin
        ctrl_o.b_en = 1'b1;
        state_d     = ST_CMP;
      end
      ST_CMP:   state_d = a_gt_b_i ? ST_WR_I : ST_NEXT;
      ST_WR_I: begin
        ctrl_o.wdat_b = 1'b1;
        ctrl_o.wr     = 1'b1;
        state_d       = ST_WR_J;
      end
      ST_WR_J: begin
        ctrl_o.addr_j = 1'b1;
        ctrl_o.wr     = 1'b1;
        state_d       = ST_RL_RD;
      end
      ST_RL_RD: state_d = ST_RL_LD;
      ST_RL_LD: begin
        ctrl_o.a_en = 1'b1;
        state_d     = ST_NEXT;
      end
      ST_NEXT: begin
        if (!j_last_i) begin
          ctrl_o.j_inc = 1'b1;
          state_d      = ST_RD_B;
        end else if (!i_last_i) begin
          ctrl_o.i_inc = 1'b1;
          state_d      = ST_RD_A;
        end else begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        ctrl_o.host_sel = 1'b1;
        if (!mode_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign done_o = (state_q == ST_DONE);

  assert_done_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_i) |=> done_o);
  assert_done_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> !$past(mode_i));
  // after each compare step A holds the minimum of the pair
  assert_min_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NEXT) |-> !a_gt_b_i);
endmodule

// File: rtl/xsort_engine.sv
module xsort_engine
  import xsort_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int COUNT  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              host_wr_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_data_i,
  input  logic              host_rd_en_i,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  xs_ctrl_t ctrl;
  logic     i_last, j_last, a_gt_b;

  initial begin
    assert_count_fits_R3: assert (COUNT >= 2 && COUNT <= (1 << ADDR_W));
  end

  xsort_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .i_last_i (i_last),
    .j_last_i (j_last),
    .a_gt_b_i (a_gt_b),
    .ctrl_o   (ctrl),
    .done_o   (done_o)
  );

  xsort_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .COUNT(COUNT)) u_dp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_i       (ctrl),
    .host_wr_i    (host_wr_i),
    .host_addr_i  (host_addr_i),
    .host_data_i  (host_data_i),
    .host_rd_en_i (host_rd_en_i),
    .data_o       (data_o),
    .i_last_o     (i_last),
    .j_last_o     (j_last),
    .a_gt_b_o     (a_gt_b)
  );
endmodule

// File: tb/sim_xsort_engine.sv
module sim_xsort_engine;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam int K  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode = 1'b0;
  logic          hwr = 1'b0;
  logic [AW-1:0] haddr = '0;
  logic [DW-1:0] hdata = '0;
  logic          hrd = 1'b0;
  logic [DW-1:0] dout;
  logic          done;

  int errors = 0;
  int checks = 0;
  int ref_mem [K];
  int ref_swaps;

  always #4 clk = ~clk;

  xsort_engine #(.DATA_W(DW), .ADDR_W(AW), .COUNT(K)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .host_wr_i(hwr),
    .host_addr_i(haddr), .host_data_i(hdata), .host_rd_en_i(hrd),
    .data_o(dout), .done_o(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic host_write(input int a, input int d);
    @(negedge clk);
    hwr = 1'b1; haddr = AW'(a); hdata = DW'(d);
    @(negedge clk);
    hwr = 1'b0;
  endtask

  task automatic host_read(input int a, output int d);
    @(negedge clk);
    haddr = AW'(a); hrd = 1'b1;
    @(negedge clk);
    d = int'(dout);
    hrd = 1'b0;
  endtask

  // load array and build the expected result and exchange count
  task automatic load(input int v0, input int v1, input int v2, input int v3);
    int tmp;
    ref_mem[0] = v0; ref_mem[1] = v1; ref_mem[2] = v2; ref_mem[3] = v3;
    for (int n = 0; n < K; n++) host_write(n, ref_mem[n]);
    ref_swaps = 0;
    for (int i = 0; i < K - 1; i++)
      for (int j = i + 1; j < K; j++)
        if (ref_mem[i] > ref_mem[j]) begin
          tmp = ref_mem[i]; ref_mem[i] = ref_mem[j]; ref_mem[j] = tmp;
          ref_swaps++;
        end
  endtask

  task automatic run_sort(input string tag, input bit jam);
    int cnt = 0;
    @(negedge clk);
    mode = 1'b1;
    do begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (jam && cnt == 1) begin hwr = 1'b1; haddr = '0; hdata = 8'hAA; end
    end while (!done && cnt < 2000);
    hwr = 1'b0;
    check({tag, " R5 cycles"}, cnt, 1 + 2*(K-1) + 2*K*(K-1) + 4*ref_swaps);
  endtask

  task automatic verify_mem(input string tag);
    int d;
    for (int n = 0; n < K; n++) begin
      host_read(n, d);
      check({tag, " R3 word"}, d, ref_mem[n]);
    end
  endtask

  task automatic finish_sort;
    @(negedge clk);
    mode = 1'b0;
    @(negedge clk);
    check("R4 done cleared", int'(done), 0);
  endtask

  task automatic t_reset;
    check("R6 done at reset", int'(done), 0);
    check("R2 gated output", int'(dout), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_host_rw;
    int d;
    host_write(2, 8'h5C);
    host_read(2, d);
    check("R1 host write", d, 8'h5C);
    @(negedge clk); haddr = 2'd2; hrd = 1'b0;
    @(negedge clk);
    check("R2 gated after read", int'(dout), 0);
  endtask

  task automatic t_basic;
    load(3, 2, 4, 1);
    check("R5 swap count", ref_swaps, 4);
    run_sort("basic", 1'b0);
    verify_mem("basic while done");
    repeat (3) @(negedge clk);
    check("R4 done held", int'(done), 1);
    finish_sort();
  endtask

  task automatic t_equal;
    load(5, 5, 5, 5);
    run_sort("equal", 1'b0);
    finish_sort();
    verify_mem("equal");
  endtask

  task automatic t_sorted_dup;
    load(1, 2, 3, 4);
    run_sort("sorted", 1'b0);
    finish_sort();
    verify_mem("sorted");
    load(9, 3, 9, 3);
    run_sort("dup", 1'b0);
    finish_sort();
    verify_mem("dup");
  endtask

  task automatic t_jam;
    load(255, 128, 7, 0);
    run_sort("R7 jam", 1'b1);
    finish_sort();
    verify_mem("R7 jam");
  endtask

  task automatic t_reset_keep;
    load(40, 10, 30, 20);
    run_sort("pre-reset", 1'b0);
    @(negedge clk);
    mode = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R6 done cleared", int'(done), 0);
    rst_n = 1'b1;
    verify_mem("R6 kept");
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3;
    t_reset();
    t_host_rw();
    t_basic();
    t_equal();
    t_sorted_dup();
    t_jam();
    t_reset_keep();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule